// File: doc/BRIEF.md
# Synthesizer Control Word Register

This block holds the control word of a frequency synthesizer: a 9-bit feedback multiplier, a 2-bit post-divide select and a 3-bit test-output select. Two load paths write the same word. The first is a three-wire serial port with a clock, a data line and a commit strobe. The second is a parallel port with multiplier and divide-select buses and a load strobe. All port inputs are sampled on the system clock, and edges on the strobes are found by comparing each input with its value one cycle earlier.

The serial port shifts one bit into a 14-bit register on each rise of its clock. When its commit strobe falls, the whole word moves into the configuration latches. The parallel port works as a transparent latch. While its load strobe is low the latches follow the parallel buses. When the strobe rises, the value on the buses at that moment is kept. The parallel port wins over the serial port: a serial commit that occurs while the parallel strobe is low, or in the cycle it rises, is dropped. The block outputs the latched fields, a one-hot form of the divide ratio, and a flag that is set when the multiplier lies outside the range in which the loop can lock.

Top module: `synth_cfg_reg`

## Requirements
- R1: After reset the multiplier output is all ones (9'h1FF), the divide select is 2'b11 and the test select is 3'b000. With the default window this raises the out-of-range flag, and the one-hot ratio is 4'b1000.
- R2: Each 0-to-1 change of the serial clock shifts the serial data bit into bit 0 of the 14-bit shift register, and the older bits move one place toward bit 13. Nothing shifts while the serial clock stays level.
- R3: A 1-to-0 change of the serial commit strobe while the parallel strobe is high and not rising loads the latches. Test select takes shift bits [13:11], divide select takes bits [10:9] and the multiplier takes bits [8:0], so the first bit sent is the MSB of the test select. The outputs change one clock after the cycle in which the strobe is seen low.
- R4: While the parallel strobe stays high, the latches hold their value when no serial commit fall occurs. This holds through serial shifting, a rising commit strobe and any activity on the parallel buses.
- R5: A 0-to-1 change of the parallel strobe captures the parallel multiplier and divide-select buses as they are in that cycle. The test select is left unchanged.
- R6: While the parallel strobe is low, the multiplier and divide select follow the parallel buses one clock later, and falls of the serial commit strobe are ignored.
- R7: The one-hot ratio output is 4'b0001 for divide select 00 (divide by 1), 4'b0010 for 01 (by 2), 4'b0100 for 10 (by 4) and 4'b1000 for 11 (by 8).
- R8: The out-of-range flag is high exactly when the latched multiplier is below M_MIN or above M_MAX. The defaults are M_MIN = 100 and M_MAX = 400, and both bounds are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, sampled |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Serial commit strobe, acts on its falling change |
| parLoad | input | 1 | Parallel load strobe: follows while low, keeps on rise |
| parM | input | 9 | Parallel multiplier value |
| parN | input | 2 | Parallel divide select |
| mOut | output | 9 | Latched feedback multiplier |
| nOut | output | 2 | Latched divide select |
| tOut | output | 3 | Latched test-output select |
| divSel | output | 4 | One-hot divide ratio (bit k means divide by 2^k) |
| outOfRange | output | 1 | Latched multiplier outside [M_MIN, M_MAX] |

## Verification
The hardest case to reach from the ports is a collision between the two paths. A serial commit fall has to arrive while the parallel strobe is held low, or with a full serial word waiting in the shift register just as the parallel strobe rises. The stimulus first shifts in a complete random word, then opens the parallel strobe and pulses the serial commit inside that window. It then checks that the outputs show the parallel buses and not the shifted word. Random rounds mix partial shifts, commits and parallel loads. Directed cases hit each divide code and both window bounds, along with the values just outside them.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  typedef struct packed {
    logic shiftEn;
    logic serCommit;
    logic parCommit;
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serLoad,
  input  logic       parLoad,
  output cfgStrobe_t stb
);
  logic serClkQ, serLoadQ, parLoadQ;
  logic serClkRise, serLoadFall, parLoadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ  <= 1'b0;
      serLoadQ <= 1'b0;
      parLoadQ <= 1'b1;
    end else begin
      serClkQ  <= serClk;
      serLoadQ <= serLoad;
      parLoadQ <= parLoad;
    end
  end

  always_comb begin
    serClkRise    = serClk & ~serClkQ;
    serLoadFall   = ~serLoad & serLoadQ;
    parLoadRise   = parLoad & ~parLoadQ;
    stb.shiftEn   = serClkRise;
    // parallel path is transparent while low and freezes on the rise
    stb.parCommit = ~parLoad | parLoadRise;
    stb.serCommit = serLoadFall & ~stb.parCommit;
  end
endmodule

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 3,
  parameter int M_MIN = 100,
  parameter int M_MAX = 400
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           stb,
  input  logic                 serData,
  input  logic [M_W-1:0]       parM,
  input  logic [N_W-1:0]       parN,
  output logic [M_W-1:0]       mOut,
  output logic [N_W-1:0]       nOut,
  output logic [T_W-1:0]       tOut,
  output logic [(1<<N_W)-1:0]  divSel,
  output logic                 outOfRange
);
  localparam int SR_W  = T_W + N_W + M_W;
  localparam int DIV_W = 1 << N_W;
  localparam int N_LO  = M_W;
  localparam int T_LO  = M_W + N_W;

  logic [SR_W-1:0] shiftReg;
  logic [M_W-1:0]  mReg;
  logic [N_W-1:0]  nReg;
  logic [T_W-1:0]  tReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[SR_W-2:0], serData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg <= '1;
      nReg <= '1;
      tReg <= '0;
    end else if (stb.parCommit) begin
      mReg <= parM;
      nReg <= parN;
    end else if (stb.serCommit) begin
      mReg <= shiftReg[M_W-1:0];
      nReg <= shiftReg[N_LO +: N_W];
      tReg <= shiftReg[T_LO +: T_W];
    end
  end

  for (genvar g = 0; g < DIV_W; g++) begin : g_div
    assign divSel[g] = (nReg == N_W'(g));
  end

  always_comb begin
    outOfRange = (int'(mReg) < M_MIN) || (int'(mReg) > M_MAX);
    mOut = mReg;
    nOut = nReg;
    tOut = tReg;
  end
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 3,
  parameter int M_MIN = 100,
  parameter int M_MAX = 400
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClk,
  input  logic                serData,
  input  logic                serLoad,
  input  logic                parLoad,
  input  logic [M_W-1:0]      parM,
  input  logic [N_W-1:0]      parN,
  output logic [M_W-1:0]      mOut,
  output logic [N_W-1:0]      nOut,
  output logic [T_W-1:0]      tOut,
  output logic [(1<<N_W)-1:0] divSel,
  output logic                outOfRange
);
  cfgStrobe_t stb;

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
    .parLoad(parLoad), .stb(stb)
  );

  synth_cfg_dp #(
    .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .serData(serData),
    .parM(parM), .parN(parN), .mOut(mOut), .nOut(nOut), .tOut(tOut),
    .divSel(divSel), .outOfRange(outOfRange)
  );
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 3,
  parameter int M_MIN = 100,
  parameter int M_MAX = 400
)(
  input logic                clk,
  input logic                rstN,
  input logic                serLoad,
  input logic                parLoad,
  input logic [M_W-1:0]      parM,
  input logic [N_W-1:0]      parN,
  input logic [M_W-1:0]      mOut,
  input logic [N_W-1:0]      nOut,
  input logic [T_W-1:0]      tOut,
  input logic [(1<<N_W)-1:0] divSel,
  input logic                outOfRange
);
  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(divSel) == 1 && divSel[nOut]); // R7

  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (int'(mOut) >= M_MIN && int'(mOut) <= M_MAX) |-> !outOfRange); // R8

  AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parLoad) |=> (mOut == $past(parM) && nOut == $past(parN) && $stable(tOut))); // R5

  AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    !parLoad |=> (mOut == $past(parM) && nOut == $past(parN) && $stable(tOut))); // R6

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (parLoad && !$rose(parLoad) && !$fell(serLoad)) |=>
      ($stable(mOut) && $stable(nOut) && $stable(tOut))); // R4
endmodule

bind synth_cfg_reg synth_cfg_chk #(
  .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .serLoad(serLoad), .parLoad(parLoad),
  .parM(parM), .parN(parN), .mOut(mOut), .nOut(nOut), .tOut(tOut),
  .divSel(divSel), .outOfRange(outOfRange)
);

// File: tb/synth_cfg_reg_bench.sv
module synth_cfg_reg_bench;
  localparam int MMIN = 100;
  localparam int MMAX = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, parLoad = 1'b1;
  logic [8:0] parM = '1;
  logic [1:0] parN = '1;
  logic [8:0] mOut;
  logic [1:0] nOut;
  logic [2:0] tOut;
  logic [3:0] divSel;
  logic outOfRange;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [13:0] expSr = '0;
  logic [8:0]  expM = '1;
  logic [1:0]  expN = '1;
  logic [2:0]  expT = '0;

  always #5 clk = ~clk;

  synth_cfg_reg u_synth_cfg_reg (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoad(parLoad), .parM(parM), .parN(parN),
    .mOut(mOut), .nOut(nOut), .tOut(tOut), .divSel(divSel),
    .outOfRange(outOfRange)
  );

  function automatic logic [3:0] ratioOf(input logic [1:0] n);
    return 4'b0001 << n;
  endfunction

  function automatic logic oorOf(input logic [8:0] m);
    return (int'(m) < MMIN) || (int'(m) > MMAX);
  endfunction

  task automatic checkAll(input string tag);
    logic [3:0] eD;
    logic eO;
    eD = ratioOf(expN);
    eO = oorOf(expM);
    checks++;
    if (mOut !== expM || nOut !== expN || tOut !== expT ||
        divSel !== eD || outOfRange !== eO) begin
      errors++;
      $display("FAIL %s: got m=%0d n=%0d t=%0d div=%b oor=%b exp m=%0d n=%0d t=%0d div=%b oor=%b",
               tag, mOut, nOut, tOut, divSel, outOfRange, expM, expN, expT, eD, eO);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serData = b; serClk = 1'b1;
    @(negedge clk); serClk = 1'b0;
    expSr = {expSr[12:0], b};
  endtask

  task automatic shiftWord(input logic [13:0] w, input int nBits);
    for (int i = nBits - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic serCommit();
    @(negedge clk); serLoad = 1'b1;
    @(negedge clk); serLoad = 1'b0;
    @(negedge clk);
    if (parLoad) begin
      expT = expSr[13:11];
      expN = expSr[10:9];
      expM = expSr[8:0];
    end
  endtask

  task automatic parWrite(input logic [8:0] m, input logic [1:0] n, input bit collide);
    @(negedge clk); parLoad = 1'b0; parM = ~m; parN = ~n;
    @(negedge clk); parM = m; parN = n;
    @(negedge clk);
    expM = m; expN = n;
    checkAll("R6 track while low");
    if (collide) begin
      serLoad = 1'b1;
      @(negedge clk); serLoad = 1'b0;
      @(negedge clk);
      checkAll("R6 serial commit ignored while low");
    end
    parLoad = 1'b1;
    @(negedge clk);
    checkAll("R5 capture on rise");
    parM = ~m; parN = ~n;
    @(negedge clk); @(negedge clk);
    checkAll("R4 parallel buses ignored while high");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [13:0] w;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset state");

    // R2 R3: full word, MSB first
    w = {3'b101, 2'b01, 9'd250};
    shiftWord(w, 14);
    checkAll("R4 shift without commit holds latches");
    serCommit();
    checkAll("R3 serial commit full word");

    // R2: partial shift then commit keeps the older bits
    shiftWord(14'h0005, 3);
    serCommit();
    checkAll("R2 partial shift commit");

    // R4: serial load rising only, no fall
    @(negedge clk); serLoad = 1'b1;
    @(negedge clk); @(negedge clk);
    checkAll("R4 commit strobe rise alone");
    @(negedge clk); serLoad = 1'b0;
    @(negedge clk); @(negedge clk);
    expT = expSr[13:11]; expN = expSr[10:9]; expM = expSr[8:0];
    checkAll("R3 delayed fall commits");

    // R7 each divide code via parallel path
    for (int n = 0; n < 4; n++) parWrite(9'd200, 2'(n), 1'b0);

    // R8 window bounds
    parWrite(9'd99, 2'd0, 1'b0);
    parWrite(9'd100, 2'd1, 1'b0);
    parWrite(9'd400, 2'd2, 1'b0);
    parWrite(9'd401, 2'd3, 1'b0);
    parWrite(9'd0, 2'd0, 1'b0);

    // R6 collision: full serial word pending while parallel window open
    shiftWord({3'b111, 2'b10, 9'd300}, 14);
    parWrite(9'd123, 2'd1, 1'b1);
    checkAll("R5 test select kept by parallel load");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: shiftWord(14'($urandom), 14);
        1: shiftWord(14'($urandom), 1 + int'($urandom % 13));
        2: begin serCommit(); checkAll("R3 random commit"); end
        default: parWrite(9'($urandom), 2'($urandom), bit'($urandom % 2));
      endcase
    end
    serCommit();
    checkAll("R3 final commit");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule